// File: doc/BRIEF.md
# GPIO Port Configuration and Pad Multiplexer

This block controls one port of up to 32 general-purpose pins through a 32-bit memory-mapped register interface. Four per-pin configuration vectors are read in layers to give each pin a role:

- The interrupt-select bit takes precedence.
- When it is clear, the gate bit chooses between a peripheral function and plain GPIO.
- The two pattern bits then give the function number, the direction and output value, or the trigger type.

From the decoded roles the block drives each pad's output enable and output value. It also produces a per-pin peripheral-function enable and a 2-bit function index, and exports the trigger configuration for an external interrupt detector.

Every writable register can be written in three ways, each at its own address:

- a plain write, which replaces the whole register;
- a set alias, which sets the bits written as 1;
- a clear alias, which clears the bits written as 1.

Software therefore never needs a read-modify-write to change one pin.

A pull-off register turns the pad pull resistors off. A pull only takes effect on pins that two fixed capability masks mark as pull-up or pull-down capable. The live pad levels pass through a two-flop synchronizer and are readable as one word. A flag word from the external interrupt detector is also readable.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset every pin is a GPIO input: interrupt-select reads 0, gate reads all ones, pattern-high reads all ones, pattern-low reads 0, and pull-off reads the inverse of the union of the two capability masks. pad_oe, func_en and irq_en are all 0.
- R2: Register addresses use page = addr[7:4] and operation = addr[3:2]. The pages are: 0 pin level, 1 interrupt-select, 2 gate, 3 pattern-high, 4 pattern-low, 5 flag, 7 pull-off. A read at operation 0 returns the register. A write at operation 0 replaces it. A read at operation 1 (set) or 2 (clear) returns 0.
- R3: A write at operation 1 sets exactly the bits written as 1 and leaves the other bits unchanged.
- R4: A write at operation 2 clears exactly the bits written as 1 and leaves the other bits unchanged.
- R5: With interrupt-select 0 and gate 0, the pin is in peripheral mode: func_en is 1, func_sel = {pattern-high, pattern-low}, and pad_oe is 0. func_sel is 0 for pins in any other role.
- R6: With interrupt-select 0, gate 1 and pattern-high 0, the pin is a GPIO output: pad_oe is 1 and pad_out equals pattern-low.
- R7: With interrupt-select 1, the pin is an undriven input: pad_oe = 0 and func_en = 0. In this role irq_en = NOT gate, irq_edge = pattern-high, and irq_high = pattern-low. All three are 0 when interrupt-select is 0.
- R8: A read of page 0 returns pad_in as it was two clock edges earlier.
- R9: pull_up_en = NOT pull-off AND the pull-up mask. pull_dn_en = NOT pull-off AND the pull-down mask AND NOT the pull-up mask. A pin in neither mask never pulls, whatever its pull-off bit.
- R10: The following are ignored and change no register:
  - writes to pages 0 and 5;
  - writes to unmapped pages;
  - writes at operation 3;
  - accesses with addr[1:0] not 0.

  Reads of unmapped pages return 0. Page 5 reads irq_flag_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Read data, combinational during a read |
| pad_in | input | N_PINS | Asynchronous pad levels |
| irq_flag_in | input | N_PINS | Pending flags from the external interrupt detector |
| pad_oe | output | N_PINS | Pad output enable |
| pad_out | output | N_PINS | Pad output value |
| func_en | output | N_PINS | Pin owned by a peripheral function |
| func_sel | output | 2*N_PINS | 2-bit function index per pin, pin i at [2i+1:2i] |
| irq_en | output | N_PINS | Interrupt enabled for the pin |
| irq_edge | output | N_PINS | 1 = edge trigger, 0 = level trigger |
| irq_high | output | N_PINS | 1 = rising/high, 0 = falling/low |
| pull_up_en | output | N_PINS | Pull-up active |
| pull_dn_en | output | N_PINS | Pull-down active |

## Verification
The assertions check on every cycle:
- that set and clear aliases touch only the bits written as 1 and keep the others;
- that no register moves without a decoded write;
- that a pin never holds two roles at once, and that an interrupt pin never drives;
- that the level word trails pad_in by exactly two edges;
- that up and down pulls never coincide.

Only the bench's scenarios can show the things a property cannot see:
- the address map itself;
- the reset values;
- the exact function index chosen for particular pattern combinations;
- that ignored writes, at reserved operations, misaligned offsets and read-only pages, really leave state untouched.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int CFG_COUNT = 5;

    // Index of each writable configuration word inside the register file
    localparam logic [2:0] CFG_IRQSEL   = 3'd0;
    localparam logic [2:0] CFG_GATE     = 3'd1;
    localparam logic [2:0] CFG_PAT_HI   = 3'd2;
    localparam logic [2:0] CFG_PAT_LO   = 3'd3;
    localparam logic [2:0] CFG_PULL_OFF = 3'd4;
    localparam logic [2:0] CFG_NONE     = 3'd7;

    // Address pages (addr[7:4])
    localparam logic [3:0] PAGE_LEVEL    = 4'd0;
    localparam logic [3:0] PAGE_IRQSEL   = 4'd1;
    localparam logic [3:0] PAGE_GATE     = 4'd2;
    localparam logic [3:0] PAGE_PAT_HI   = 4'd3;
    localparam logic [3:0] PAGE_PAT_LO   = 4'd4;
    localparam logic [3:0] PAGE_FLAG     = 4'd5;
    localparam logic [3:0] PAGE_PULL_OFF = 4'd7;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_RSVD  = 2'd3
    } alias_op_e;

    typedef enum logic [1:0] {
        ROLE_FUNC     = 2'd0,
        ROLE_GPIO_IN  = 2'd1,
        ROLE_GPIO_OUT = 2'd2,
        ROLE_IRQ      = 2'd3
    } pin_role_e;

    function automatic logic [2:0] page_to_cfg(input logic [3:0] page);
        case (page)
            PAGE_IRQSEL:   return CFG_IRQSEL;
            PAGE_GATE:     return CFG_GATE;
            PAGE_PAT_HI:   return CFG_PAT_HI;
            PAGE_PAT_LO:   return CFG_PAT_LO;
            PAGE_PULL_OFF: return CFG_PULL_OFF;
            default:       return CFG_NONE;
        endcase
    endfunction

    function automatic pin_role_e decode_role(input logic irqsel, input logic gate,
                                              input logic pat_hi);
        if (irqsel)      return ROLE_IRQ;
        else if (!gate)  return ROLE_FUNC;
        else if (pat_hi) return ROLE_GPIO_IN;
        else             return ROLE_GPIO_OUT;
    endfunction

endpackage

// File: rtl/gpio_port_cfg_regs.sv
module gpio_port_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int                N_PINS       = 32,
    parameter logic [N_PINS-1:0] PULL_OFF_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  alias_op_e         wr_op,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] cfg_irqsel,
    output logic [N_PINS-1:0] cfg_gate,
    output logic [N_PINS-1:0] cfg_pat_hi,
    output logic [N_PINS-1:0] cfg_pat_lo,
    output logic [N_PINS-1:0] cfg_pull_off
);

    typedef struct packed {
        logic [CFG_COUNT-1:0][N_PINS-1:0] r;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int k = 0; k < CFG_COUNT; k++) begin
            if (wr_en && (wr_idx == 3'(k))) begin
                case (wr_op)
                    OP_WRITE: state_d.r[k] = wr_data;
                    OP_SET:   state_d.r[k] = state_q.r[k] | wr_data;
                    OP_CLEAR: state_d.r[k] = state_q.r[k] & ~wr_data;
                    default:  state_d.r[k] = state_q.r[k];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.r[CFG_IRQSEL]   <= '0;
            state_q.r[CFG_GATE]     <= '1;
            state_q.r[CFG_PAT_HI]   <= '1;
            state_q.r[CFG_PAT_LO]   <= '0;
            state_q.r[CFG_PULL_OFF] <= PULL_OFF_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_irqsel   = state_q.r[CFG_IRQSEL];
    assign cfg_gate     = state_q.r[CFG_GATE];
    assign cfg_pat_hi   = state_q.r[CFG_PAT_HI];
    assign cfg_pat_lo   = state_q.r[CFG_PAT_LO];
    assign cfg_pull_off = state_q.r[CFG_PULL_OFF];

    for (genvar k = 0; k < CFG_COUNT; k++) begin : g_chk
        AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == 3'(k) && wr_op == OP_SET) |=>
            (((state_q.r[k] & $past(wr_data)) == $past(wr_data)) &&
             ((state_q.r[k] & ~$past(wr_data)) == ($past(state_q.r[k]) & ~$past(wr_data))))); // R3
        AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == 3'(k) && wr_op == OP_CLEAR) |=>
            (((state_q.r[k] & $past(wr_data)) == '0) &&
             ((state_q.r[k] & ~$past(wr_data)) == ($past(state_q.r[k]) & ~$past(wr_data))))); // R4
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_op == OP_RSVD) |=> $stable(state_q)); // R10

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] level_o
);

    typedef struct packed {
        logic [N_PINS-1:0] stage1;
        logic [N_PINS-1:0] stage2;
        logic [1:0]        settle;
    } sync_state_t;

    sync_state_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = pad_in;
        sync_d.stage2 = sync_q.stage1;
        if (sync_q.settle != 2'd2) begin
            sync_d.settle = sync_q.settle + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level_o = sync_q.stage2;

    AST_LEVEL_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q.settle == 2'd2) |-> (level_o == $past(pad_in, 2))); // R8

endmodule

// File: rtl/gpio_port_role_decode.sv
module gpio_port_role_decode
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PINS-1:0]      cfg_irqsel,
    input  logic [N_PINS-1:0]      cfg_gate,
    input  logic [N_PINS-1:0]      cfg_pat_hi,
    input  logic [N_PINS-1:0]      cfg_pat_lo,
    output logic [N_PINS-1:0]      pad_oe,
    output logic [N_PINS-1:0]      pad_out,
    output logic [N_PINS-1:0]      func_en,
    output logic [N_PINS-1:0][1:0] func_sel,
    output logic [N_PINS-1:0]      irq_en,
    output logic [N_PINS-1:0]      irq_edge,
    output logic [N_PINS-1:0]      irq_high
);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        pin_role_e role;

        always_comb begin
            role        = decode_role(cfg_irqsel[i], cfg_gate[i], cfg_pat_hi[i]);
            pad_oe[i]   = 1'b0;
            pad_out[i]  = 1'b0;
            func_en[i]  = 1'b0;
            func_sel[i] = 2'b00;
            irq_en[i]   = 1'b0;
            irq_edge[i] = 1'b0;
            irq_high[i] = 1'b0;
            case (role)
                ROLE_FUNC: begin
                    func_en[i]  = 1'b1;
                    func_sel[i] = {cfg_pat_hi[i], cfg_pat_lo[i]};
                end
                ROLE_GPIO_OUT: begin
                    pad_oe[i]  = 1'b1;
                    pad_out[i] = cfg_pat_lo[i];
                end
                ROLE_IRQ: begin
                    irq_en[i]   = ~cfg_gate[i];
                    irq_edge[i] = cfg_pat_hi[i];
                    irq_high[i] = cfg_pat_lo[i];
                end
                default: ;
            endcase
        end

        AST_ONE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({pad_oe[i], func_en[i], cfg_irqsel[i]})); // R5
        AST_OUT_TRACKS_PATLO: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[i] |-> (pad_out[i] == cfg_pat_lo[i])); // R6
        AST_IRQ_PIN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_irqsel[i] |-> (!pad_oe[i] && !func_en[i])); // R7
        AST_NO_IRQ_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_irqsel[i] |-> (!irq_en[i] && !irq_edge[i] && !irq_high[i])); // R7
    end

endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
    import gpio_port_pkg::*;
#(
    parameter int                N_PINS     = 32,
    parameter int                ADDR_W     = 8,
    parameter logic [N_PINS-1:0] PULLUP_CAP = 32'h0F0F_00FF,
    parameter logic [N_PINS-1:0] PULLDN_CAP = 32'hF000_FF00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [N_PINS-1:0]     bus_wdata,
    output logic [N_PINS-1:0]     bus_rdata,
    input  logic [N_PINS-1:0]     pad_in,
    input  logic [N_PINS-1:0]     irq_flag_in,
    output logic [N_PINS-1:0]     pad_oe,
    output logic [N_PINS-1:0]     pad_out,
    output logic [N_PINS-1:0]     func_en,
    output logic [2*N_PINS-1:0]   func_sel,
    output logic [N_PINS-1:0]     irq_en,
    output logic [N_PINS-1:0]     irq_edge,
    output logic [N_PINS-1:0]     irq_high,
    output logic [N_PINS-1:0]     pull_up_en,
    output logic [N_PINS-1:0]     pull_dn_en
);

    localparam int                OP_LSB       = 2;
    localparam int                PAGE_LSB     = 4;
    localparam int                DEC_BITS     = PAGE_LSB + 4;
    localparam logic [N_PINS-1:0] PULL_CAPABLE = PULLUP_CAP | PULLDN_CAP;
    localparam logic [N_PINS-1:0] PULL_OFF_RST = ~PULL_CAPABLE;

    logic [3:0]        page;
    alias_op_e         op;
    logic              addr_ok;
    logic [2:0]        wr_idx;
    logic              wr_en;
    logic [N_PINS-1:0] cfg_irqsel, cfg_gate, cfg_pat_hi, cfg_pat_lo, cfg_pull_off;
    logic [N_PINS-1:0] level_sync;
    logic [N_PINS-1:0][1:0] func_sel_pk;

    assign page   = bus_addr[PAGE_LSB +: 4];
    assign op     = alias_op_e'(bus_addr[OP_LSB +: 2]);
    assign wr_idx = page_to_cfg(page);

    always_comb begin
        addr_ok = (bus_addr[OP_LSB-1:0] == '0);
        if (ADDR_W > DEC_BITS) begin
            addr_ok = addr_ok && ((bus_addr >> DEC_BITS) == '0);
        end
    end

    assign wr_en = bus_valid && bus_write && addr_ok && (wr_idx != CFG_NONE);

    gpio_port_cfg_regs #(
        .N_PINS      (N_PINS),
        .PULL_OFF_RST(PULL_OFF_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_op       (op),
        .wr_data     (bus_wdata),
        .cfg_irqsel  (cfg_irqsel),
        .cfg_gate    (cfg_gate),
        .cfg_pat_hi  (cfg_pat_hi),
        .cfg_pat_lo  (cfg_pat_lo),
        .cfg_pull_off(cfg_pull_off)
    );

    gpio_port_sync #(.N_PINS(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level_o(level_sync)
    );

    gpio_port_role_decode #(.N_PINS(N_PINS)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_irqsel(cfg_irqsel),
        .cfg_gate  (cfg_gate),
        .cfg_pat_hi(cfg_pat_hi),
        .cfg_pat_lo(cfg_pat_lo),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .func_en   (func_en),
        .func_sel  (func_sel_pk),
        .irq_en    (irq_en),
        .irq_edge  (irq_edge),
        .irq_high  (irq_high)
    );

    assign func_sel = func_sel_pk;

    // Pull-up wins on a pin that both masks would claim
    assign pull_up_en = ~cfg_pull_off & PULLUP_CAP;
    assign pull_dn_en = ~cfg_pull_off & PULLDN_CAP & ~PULLUP_CAP;

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write && addr_ok && op == OP_WRITE) begin
            case (page)
                PAGE_LEVEL:    bus_rdata = level_sync;
                PAGE_IRQSEL:   bus_rdata = cfg_irqsel;
                PAGE_GATE:     bus_rdata = cfg_gate;
                PAGE_PAT_HI:   bus_rdata = cfg_pat_hi;
                PAGE_PAT_LO:   bus_rdata = cfg_pat_lo;
                PAGE_FLAG:     bus_rdata = irq_flag_in;
                PAGE_PULL_OFF: bus_rdata = cfg_pull_off;
                default:       bus_rdata = '0;
            endcase
        end
    end

    AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && op != OP_WRITE) |-> (bus_rdata == '0)); // R2
    AST_PULL_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_up_en & pull_dn_en) == '0)); // R9
    AST_PULL_ONLY_CAPABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (((pull_up_en | pull_dn_en) & ~PULL_CAPABLE) == '0)); // R9

endmodule

// File: tb/gpio_port_mux_tb.sv
module gpio_port_mux_tb;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  irq_flag_in = '0;
    logic [N-1:0]  pad_oe, pad_out, func_en, irq_en, irq_edge, irq_high;
    logic [N-1:0]  pull_up_en, pull_dn_en;
    logic [2*N-1:0] func_sel;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_port_mux u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .irq_flag_in(irq_flag_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .func_en(func_en), .func_sel(func_sel), .irq_en(irq_en), .irq_edge(irq_edge),
        .irq_high(irq_high), .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
    );

    typedef struct packed {
        logic [7:0]  wa;
        logic [31:0] wd;
        logic [7:0]  ra;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t [0:NV-1] VECS = '{
        '{8'h14, 32'h0000_00F0, 8'h10, 32'h0000_00F0, 4'd3},  // R3 set interrupt-select
        '{8'h18, 32'h0000_0030, 8'h10, 32'h0000_00C0, 4'd4},  // R4 clear interrupt-select
        '{8'h10, 32'h1234_5678, 8'h10, 32'h1234_5678, 4'd2},  // R2 plain write
        '{8'h28, 32'h0000_000F, 8'h20, 32'hFFFF_FFF0, 4'd4},  // R4 gate clear
        '{8'h24, 32'h0000_0001, 8'h20, 32'hFFFF_FFF1, 4'd3},  // R3 gate set
        '{8'h38, 32'hFFFF_0000, 8'h30, 32'h0000_FFFF, 4'd4},  // R4 pattern-high clear
        '{8'h44, 32'h0000_AAAA, 8'h40, 32'h0000_AAAA, 4'd3},  // R3 pattern-low set
        '{8'h48, 32'h0000_000A, 8'h40, 32'h0000_AAA0, 4'd4},  // R4 pattern-low clear
        '{8'h74, 32'h0000_0001, 8'h70, 32'h00F0_0001, 4'd3},  // R3 pull-off set
        '{8'h78, 32'h00F0_0000, 8'h70, 32'h0000_0001, 4'd4},  // R4 pull-off clear
        '{8'h00, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000, 4'd10}, // R10 level page read-only
        '{8'h60, 32'hFFFF_FFFF, 8'h60, 32'h0000_0000, 4'd10}, // R10 unmapped page
        '{8'h1C, 32'hFFFF_FFFF, 8'h10, 32'h1234_5678, 4'd10}, // R10 reserved operation
        '{8'h11, 32'h0000_0000, 8'h14, 32'h0000_0000, 4'd2}   // R10 misaligned write, R2 alias reads 0
    };

    task automatic chk(input int req, input logic [N-1:0] act, input logic [N-1:0] exp,
                       input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] rd;
        do_reset();

        for (int v = 0; v < NV; v++) begin
            bus_wr(VECS[v].wa, VECS[v].wd);
            bus_rd(VECS[v].ra, rd);
            chk(int'(VECS[v].req), rd, VECS[v].exp, $sformatf("vector %0d", v));
        end

        // R1 reset state
        do_reset();
        bus_rd(8'h10, rd); chk(1, rd, 32'h0000_0000, "reset interrupt-select");
        bus_rd(8'h20, rd); chk(1, rd, 32'hFFFF_FFFF, "reset gate");
        bus_rd(8'h30, rd); chk(1, rd, 32'hFFFF_FFFF, "reset pattern-high");
        bus_rd(8'h40, rd); chk(1, rd, 32'h0000_0000, "reset pattern-low");
        bus_rd(8'h70, rd); chk(1, rd, 32'h00F0_0000, "reset pull-off");
        chk(1, pad_oe, '0, "reset pad_oe");
        chk(1, func_en | irq_en, '0, "reset func_en/irq_en");
        chk(9, pull_up_en, 32'h0F0F_00FF, "reset pull_up_en");
        chk(9, pull_dn_en, 32'hF000_FF00, "reset pull_dn_en");

        // R5 peripheral functions 0..3 on pins 0..3
        bus_wr(8'h28, 32'h0000_000F);
        bus_wr(8'h38, 32'h0000_0003);
        bus_wr(8'h44, 32'h0000_000A);
        #1;
        chk(5, func_en[3:0], 32'hF, "func_en pins 0-3");
        chk(5, func_sel[7:0], 32'hE4, "func_sel pins 0-3");
        chk(5, pad_oe[3:0], 32'h0, "no drive in function mode");

        // R6 GPIO outputs on pins 8..11
        bus_wr(8'h38, 32'h0000_0F00);
        bus_wr(8'h44, 32'h0000_0500);
        #1;
        chk(6, pad_oe[11:8], 32'hF, "pad_oe pins 8-11");
        chk(6, pad_out[11:8], 32'h5, "pad_out pins 8-11");
        bus_wr(8'h48, 32'h0000_0100);
        #1 chk(6, pad_out[11:8], 32'h4, "pad_out after clear");

        // R7 interrupt role overrides output and gate
        bus_wr(8'h14, 32'h0000_0100);
        #1 chk(7, pad_oe[11:8], 32'hE, "irq pin stops driving");
        bus_wr(8'h14, 32'h00F0_0000);
        bus_wr(8'h28, 32'h0030_0000);
        bus_wr(8'h38, 32'h0010_0000);
        bus_wr(8'h44, 32'h00A0_0000);
        #1;
        chk(7, irq_en[23:20], 32'h3, "irq_en pins 20-23");
        chk(7, irq_edge[23:20], 32'hE, "irq_edge pins 20-23");
        chk(7, irq_high[23:20], 32'hA, "irq_high pins 20-23");
        chk(7, func_en[23:20] | pad_oe[23:20], 32'h0, "irq pins not function/driven");
        chk(7, irq_en[3:0] | irq_edge[3:0], 32'h0, "no irq config outside irq role");

        // R8 two-edge synchronizer latency
        @(negedge clk);
        pad_in = 32'hCAFE_F00D;
        bus_rd(8'h00, rd); chk(8, rd, 32'h0000_0000, "level after one edge");
        bus_rd(8'h00, rd); chk(8, rd, 32'hCAFE_F00D, "level after two edges");

        // R10 flag page read-only, flag alias zero
        irq_flag_in = 32'h0000_55AA;
        bus_rd(8'h50, rd); chk(10, rd, 32'h0000_55AA, "flag read");
        bus_wr(8'h58, 32'hFFFF_FFFF);
        bus_rd(8'h58, rd); chk(2, rd, 32'h0, "flag alias reads 0");

        // R9 pulls gated by capability
        bus_wr(8'h74, 32'h0000_0101);
        #1;
        chk(9, pull_up_en, 32'h0F0F_00FE, "pull_up_en after pull-off set");
        chk(9, pull_dn_en, 32'hF000_FE00, "pull_dn_en after pull-off set");
        bus_wr(8'h78, 32'h00F0_0000);
        #1 chk(9, pull_up_en[23:20] | pull_dn_en[23:20], 32'h0, "incapable pins never pull");

        finish_run();
    end

endmodule